// File: doc/BRIEF.md
# Serial-Load Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit serial-input converter. A host drives three pins: a serial data line, a shift clock and an active-low load strobe. Each rising shift-clock edge pushes one bit into a 12-bit shift register, most significant bit first. A second 12-bit holding register drives the parallel code output. While the strobe is high the holding register keeps its value. While the strobe is low it is transparent and follows the shift register, including bits that arrive during that time. On the rising edge of the strobe it keeps the value it has at that moment.

All three pins are sampled by a fast system clock. A two-flop synchronizer brings them into that domain, and the shift clock is edge-detected there. The holding register is run by a two-state machine. `ST_HOLD` keeps the code. `ST_FOLLOW` copies the shift register's next value on every cycle. The ENTER transition (strobe seen low) moves from `ST_HOLD` to `ST_FOLLOW` and copies in the same cycle. The LATCH transition (strobe seen high again) moves from `ST_FOLLOW` back to `ST_HOLD`, and that cycle also copies. A pin change reaches the code output on the third system-clock edge after it.

Top module: `sdac_serial_front`

## Requirements
- R1: Each rising edge of `sclk_pin` shifts the register left by one bit and puts `sdat_pin` into bit 0. After 12 edges, the bit sent first sits in bit 11 of the value that a load makes visible on `code`.
- R2: The shift on a rising `sclk_pin` edge takes place whether `load_n_pin` is high or low.
- R3: When more than 12 bits are clocked in, only the last 12 are kept. Earlier bits drop off the top end.
- R4: While `load_n_pin` stays high, `code` does not change, even while bits are being shifted in.
- R5: While `load_n_pin` is low, `code` equals the shift register and follows each newly shifted bit.
- R6: When `load_n_pin` rises, `code` keeps the shift register value of that moment. Bits shifted in afterwards do not change it.
- R7: Holding `load_n_pin` low without any `sclk_pin` edge leaves the shift register unchanged.
- R8: If a `sclk_pin` rise and a `load_n_pin` rise are seen in the same system clock cycle, the shift comes first and `code` keeps the newly shifted value.
- R9: `code_upd` is high for exactly one cycle, and only in the cycle in which `code` takes a value different from its previous one. Reloading an identical value gives no pulse.
- R10: A synchronous active-low reset clears the shift register and `code` to 0x000 and holds `code_upd` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdat_pin | input | 1 | Serial data, MSB first |
| sclk_pin | input | 1 | Shift clock, acts on rising edges |
| load_n_pin | input | 1 | Active-low, level-sensitive load strobe |
| code | output | 12 | Holding register contents (parallel code) |
| code_upd | output | 1 | One-cycle pulse when `code` changes |

## Verification
The bench sweeps a spread of 12-bit codes plus the all-zero, all-one and alternating patterns. For each it checks that `code` stays put while the bits are shifted in with the strobe high, and that it equals the word after a load pulse. A bit-order or hold fault shows there as a reversed word or a drifting output. Over-long words show whether stale leading bits survive. A transparent pass checks `code` after each bit, so a design that only latches on the edge falls behind. A shift clock and strobe that rise together show whether the pre-shift value was captured by mistake. The update pulse is counted across identical and differing reloads, and a strobe held low with no clock edges must not disturb the shift register.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    // Holding register control states
    typedef enum logic [0:0] {
        ST_HOLD   = 1'b0,   // keep code
        ST_FOLLOW = 1'b1    // copy shift register every cycle
    } hold_state_e;

    localparam int unsigned SDAC_CODE_W   = 12;
    localparam int unsigned SDAC_SYNC_LEN = 2;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int unsigned    W       = 1,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] d;
        if (g == 0) begin : g_first
            assign d = async_i;
        end else begin : g_next
            assign d = stage_q[g-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              bit_i,
    output logic [CODE_W-1:0] sh_q,
    output logic [CODE_W-1:0] sh_next
);
    // Next value is exported so that a same-cycle latch sees the shifted word
    always_comb begin
        if (step_i) sh_next = {sh_q[CODE_W-2:0], bit_i};
        else        sh_next = sh_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_next;
    end
endmodule

// File: rtl/sdac_hold_ctrl.sv
module sdac_hold_ctrl
    import sdac_pkg::*;
#(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lvl_i,   // synchronized strobe, low = asserted
    input  logic [CODE_W-1:0] src_i,        // shift register next value
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o,
    output hold_state_e       state_o
);
    hold_state_e state_q, state_d;
    logic        take;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Next state and copy enable
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (!load_lvl_i) begin          // ENTER
                    state_d = ST_FOLLOW;
                    take    = 1'b1;
                end
            end
            ST_FOLLOW: begin
                take = 1'b1;                    // transparent, or final copy on LATCH
                if (load_lvl_i) state_d = ST_HOLD;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // Holding register and change pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= take && (src_i != code_o);
            if (take) code_o <= src_i;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/sdac_serial_front.sv
module sdac_serial_front
    import sdac_pkg::*;
#(
    parameter int unsigned CODE_W   = SDAC_CODE_W,
    parameter int unsigned SYNC_LEN = SDAC_SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdat_pin,
    input  logic              sclk_pin,
    input  logic              load_n_pin,
    output logic [CODE_W-1:0] code,
    output logic              code_upd
);
    localparam int unsigned PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_IDLE = 3'b100;  // {load_n, sclk, sdat}

    logic [PIN_N-1:0]  pins_s;
    logic              load_lvl;
    logic              sclk_lvl;
    logic              sdat_s;
    logic              sclk_rise;
    logic [CODE_W-1:0] shreg;
    logic [CODE_W-1:0] sh_next;
    hold_state_e       hold_state;

    sdac_sync #(.W(PIN_N), .STAGES(SYNC_LEN), .RST_VAL(PIN_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({load_n_pin, sclk_pin, sdat_pin}),
        .sync_o  (pins_s)
    );

    assign load_lvl = pins_s[2];
    assign sclk_lvl = pins_s[1];
    assign sdat_s   = pins_s[0];

    sdac_edge #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sclk_lvl),
        .rise_o (sclk_rise)
    );

    sdac_shifter #(.CODE_W(CODE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (sclk_rise),
        .bit_i   (sdat_s),
        .sh_q    (shreg),
        .sh_next (sh_next)
    );

    sdac_hold_ctrl #(.CODE_W(CODE_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_lvl_i (load_lvl),
        .src_i      (sh_next),
        .code_o     (code),
        .upd_o      (code_upd),
        .state_o    (hold_state)
    );
endmodule

// File: rtl/sdac_serial_front_chk.sv
module sdac_serial_front_chk #(
    parameter int unsigned CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_lvl,
    input logic              sclk_rise,
    input logic [CODE_W-1:0] shreg,
    input logic [CODE_W-1:0] code,
    input logic              code_upd
);
    logic armed;
    always_ff @(posedge clk) armed <= rst_n;

    assert_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        sclk_rise |=> shreg[CODE_W-1:1] == $past(shreg[CODE_W-2:0]));

    assert_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (load_lvl && $past(load_lvl)) |=> $stable(code));

    assert_follow_low_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !load_lvl |=> code == shreg);

    assert_no_edge_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !sclk_rise |=> $stable(shreg));

    assert_upd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        code_upd == (code != $past(code)));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (code == '0 && shreg == '0 && !code_upd));
endmodule

bind sdac_serial_front sdac_serial_front_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_lvl  (load_lvl),
    .sclk_rise (sclk_rise),
    .shreg     (shreg),
    .code      (code),
    .code_upd  (code_upd)
);

// File: tb/sdac_serial_front_tb.sv
`timescale 1ns/1ps
module sdac_serial_front_tb;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdat_pin = 1'b0;
    logic        sclk_pin = 1'b0;
    logic        load_n_pin = 1'b1;
    logic [11:0] code;
    logic        code_upd;

    int          total = 0;
    int          bad = 0;
    int          upd_cnt = 0;
    bit          done = 0;
    logic [11:0] exp_sh = '0;
    logic [11:0] exp_code = '0;

    sdac_serial_front u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdat_pin   (sdat_pin),
        .sclk_pin   (sclk_pin),
        .load_n_pin (load_n_pin),
        .code       (code),
        .code_upd   (code_upd)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (code_upd) upd_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %03h expected %03h", tag, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdat_pin = b;
        sclk_pin = 1'b0;
        tick(HALF);
        sclk_pin = 1'b1;
        exp_sh = {exp_sh[10:0], b};
        tick(HALF);
        sclk_pin = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
        tick(4);
    endtask

    task automatic pulse_load;
        load_n_pin = 1'b0;
        tick(4);
        load_n_pin = 1'b1;
        exp_code = exp_sh;
        tick(4);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        exp_sh = '0;
        exp_code = '0;
        tick(2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R10: reset state
        chk("R10 code after reset", code, 12'h000);
        chk("R10 upd after reset", {11'd0, code_upd}, 12'h000);

        // R1 R4 R6: sweep of codes, shifted with strobe high then loaded
        begin
            logic [11:0] pats [4] = '{12'h000, 12'hFFF, 12'hAAA, 12'h555};
            for (int k = 0; k < 4; k++) begin
                send_word({4'h0, pats[k]}, 12);
                chk("R4 hold during shift", code, exp_code);
                pulse_load();
                chk("R1 loaded word", code, pats[k]);
            end
        end
        for (int v = 1; v < 4096; v += 7) begin
            send_word(v[15:0], 12);
            chk("R4 hold during shift", code, exp_code);
            pulse_load();
            chk("R1 R6 loaded word", code, v[11:0]);
        end

        // R3: over-long words keep last 12 bits
        send_word(16'hF123, 16);
        pulse_load();
        chk("R3 16-bit word", code, 12'h123);
        send_word(16'h0A5C, 14);
        pulse_load();
        chk("R3 14-bit word", code, 12'hA5C);

        // R9: identical reload gives no pulse, new value gives one
        upd_cnt = 0;
        pulse_load();
        chk("R9 no pulse on same value", upd_cnt[11:0], 12'd0);
        send_word(16'h0F0F, 12);
        upd_cnt = 0;
        pulse_load();
        chk("R9 one pulse on change", upd_cnt[11:0], 12'd1);
        chk("R9 value", code, 12'hF0F);

        // R7: strobe low with no clock edges leaves the shift register alone
        load_n_pin = 1'b0;
        tick(20);
        load_n_pin = 1'b1;
        tick(4);
        upd_cnt = 0;
        pulse_load();
        chk("R7 shift register unchanged", code, 12'hF0F);
        chk("R7 no update pulse", upd_cnt[11:0], 12'd0);

        // R2 R5: transparent mode follows every shifted bit
        load_n_pin = 1'b0;
        tick(4);
        for (int i = 11; i >= 0; i--) begin
            send_bit(12'h3C6 >> i);
            tick(2);
            chk("R5 R2 transparent follow", code, exp_sh);
        end
        // R8: shift clock and strobe rise together
        sdat_pin = 1'b1;
        tick(HALF);
        sclk_pin = 1'b1;
        load_n_pin = 1'b1;
        exp_sh = {exp_sh[10:0], 1'b1};
        exp_code = exp_sh;
        tick(HALF);
        sclk_pin = 1'b0;
        tick(4);
        chk("R8 shift before latch", code, exp_code);
        // R6: further bits do not disturb the latched code
        send_word(16'h0002, 3);
        chk("R6 latched code stays", code, exp_code);
        pulse_load();
        chk("R6 R2 shifts continued with strobe high", code, exp_sh);

        // R10: reset mid-run clears both registers
        send_word(16'h0BEE, 12);
        pulse_load();
        do_reset();
        chk("R10 code cleared", code, 12'h000);
        pulse_load();
        chk("R10 shift register cleared", code, 12'h000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule